// File: doc/BRIEF.md
# Prescaled Audio-Channel Interval Timer

One sound/timer channel that runs from a CPU-rate cycle enable. A prescaler turns the cycle enable into a slow base tick once every 28 enabled cycles, which is about 64 kHz from a CPU clock near 1.79 MHz. An 8-bit down-counter is stepped either by that base tick or directly by every CPU cycle. Each time it underflows it reloads from a divisor register and inverts the channel's toggle output. If interrupts are enabled, it also latches an interrupt request, which drives an active-low IRQ line.

Software can do four things. It writes the divisor, and the new value takes hold only at the next underflow. It picks the base clock, which takes effect on the next cycle. It sets or clears the interrupt enable, and clearing the enable also drops a pending request. It can hold an init control that stops the prescaler and resets its phase. From the release of init there is a fixed latency to the first counter step: the prescaler fires 7 enabled cycles after release, and its tick passes through a 2-cycle delay line before it steps the counter. Holding init does not stop the CPU-rate path. Because of this latency, software can align the interrupt pattern to a known cycle.

Top module: `aud_timer_chan`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), toggle_out and irq_flag are 0 and irq_n is 1.
- R2: With fast_sel=0 and init_hold low, the prescaler produces one base tick every 28 enabled cycles (cycles with cyc_en=1). Each base tick steps the counter 2 enabled cycles after it occurs.
- R3: While init_hold is 1, the prescaler and its delay line are held reset. The first counter step after release falls on the 9th enabled cycle, counting the first enabled cycle with init_hold low as the 1st (7 cycles to the tick, plus 2 of delay).
- R4: Holding init_hold does not stop the CPU-rate path. With fast_sel=1 the counter keeps stepping while init_hold is 1.
- R5: A step at count 0 is an underflow. On underflow the counter reloads from the divisor register and toggle_out inverts; otherwise a step decrements the count. Consecutive toggle changes are therefore (divisor+1) steps apart, which is (divisor+1)*28 cycles on the base tick.
- R6: A divisor write (div_wr=1, value on div_data) leaves the count in progress alone. The interval that is running when the write happens keeps the old divisor.
- R7: fast_sel=1 selects one step per enabled cycle, and fast_sel=0 selects the base tick. A change of fast_sel applies from the next clock edge.
- R8: An underflow while the interrupt enable is 1 sets irq_flag at the same edge at which toggle_out changes. irq_n is the inverse of irq_flag.
- R9: An underflow while the interrupt enable is 0 leaves irq_flag at 0.
- R10: Writing 0 to the interrupt enable (irq_en_wr=1, irq_en_data=0) clears irq_flag at that edge, which releases irq_n to 1.
- R11: When cyc_en is 0, the prescaler and the counter do not advance and toggle_out does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_en | input | 1 | CPU-rate cycle enable |
| div_wr | input | 1 | Divisor write strobe |
| div_data | input | 8 | Divisor value to write |
| fast_sel | input | 1 | 1: step every CPU cycle; 0: step on the prescaled base tick |
| irq_en_wr | input | 1 | Interrupt-enable write strobe |
| irq_en_data | input | 1 | Interrupt-enable value to write |
| init_hold | input | 1 | Stop and reset the prescaler while high |
| toggle_out | output | 1 | Channel output; inverts on each underflow |
| irq_flag | output | 1 | Latched interrupt request |
| irq_n | output | 1 | Active-low interrupt line |

## Verification
The bench releases init and counts the cycles to the first toggle change. This exposes a prescaler phase or delay line that is off by one, which would move the first step away from cycle 9. It sweeps every divisor from 0 to 31, plus 255, on the base tick. For each one it checks the interval that follows the write (it must keep the old divisor) and the interval after that (it must use the new one). An eager reload or a wrong modulus shows up as a wrong period. It also switches to the fast path right after an underflow, holds init while on the fast path, stalls cyc_en, and walks the interrupt enable through set, ignore and clear. These catch a latched base select, a fast path gated by init, a counter that runs while stalled, and a request that is latched while disabled or survives its clear.

// File: rtl/aud_timer_pkg.sv
// Shared constants and types for the prescaled audio-channel timer.
// Assumes: one CPU cycle enable drives all state; all timing is in enabled cycles.
package aud_timer_pkg;
    localparam int unsigned PRE_DIV_DEF   = 28;
    localparam int unsigned START_GAP_DEF = 7;
    localparam int unsigned PIPE_DLY_DEF  = 2;
    localparam int unsigned CNT_W_DEF     = 8;

    typedef enum logic {
        BASE_PRESCALED = 1'b0,
        BASE_CPU       = 1'b1
    } base_sel_e;
endpackage

// File: rtl/aud_prescaler.sv
// Base-tick prescaler with a fixed delay line to the counter.
// Counts enabled cycles modulo PRE_DIV. While init_hold is high, it holds a phase
// that makes the first tick come START_GAP enabled cycles after release, and it
// clears the delay line. tick_out is the tick delayed by PIPE_DLY enabled cycles.
// Assumes: PRE_DIV > START_GAP >= 1, PIPE_DLY >= 1.
module aud_prescaler #(
    parameter int unsigned PRE_DIV   = 28,
    parameter int unsigned START_GAP = 7,
    parameter int unsigned PIPE_DLY  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_en,
    input  logic init_hold,
    output logic tick_out
);
    localparam int unsigned PW = $clog2(PRE_DIV);
    localparam logic [PW-1:0] LAST_PH  = PW'(PRE_DIV - 1);
    localparam logic [PW-1:0] START_PH = PW'(PRE_DIV - START_GAP);

    logic [PW-1:0]       phase_q;
    logic [PIPE_DLY-1:0] dly_q;
    logic                tick_raw;

    // Terminal phase on an enabled cycle marks the base tick.
    assign tick_raw = cyc_en && (phase_q == LAST_PH);

    // Phase counter: held at its start phase during reset or init, wraps at PRE_DIV.
    always_ff @(posedge clk) begin
        if (!rst_n || init_hold) begin
            phase_q <= START_PH;
        end else if (cyc_en) begin
            phase_q <= (phase_q == LAST_PH) ? '0 : phase_q + 1'b1;
        end
    end

    // Delay line from tick to counter step, advancing on enabled cycles only.
    generate
        if (PIPE_DLY == 1) begin : g_dly1
            always_ff @(posedge clk) begin
                if (!rst_n || init_hold) dly_q <= '0;
                else if (cyc_en)         dly_q <= tick_raw;
            end
        end else begin : g_dlyn
            always_ff @(posedge clk) begin
                if (!rst_n || init_hold) dly_q <= '0;
                else if (cyc_en)         dly_q <= {dly_q[PIPE_DLY-2:0], tick_raw};
            end
        end
    endgenerate

    assign tick_out = dly_q[PIPE_DLY-1];

    // R3: after a full held cycle no delayed tick can reach the counter
    a_r3_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (init_hold && $past(init_hold)) |-> !tick_out);

    // R11: phase freezes when the cycle enable is low
    a_r11_phase_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_en && !init_hold) |=> $stable(phase_q));

    // R2: two base ticks are never adjacent
    a_r2_tick_sparse: assert property (@(posedge clk) disable iff (!rst_n)
        tick_raw |=> !tick_raw);
endmodule

// File: rtl/aud_down_counter.sv
// Channel down-counter with deferred divisor reload.
// A step at zero underflows: the counter reloads from the divisor register and the
// toggle output inverts. A divisor write only updates the register.
// Assumes: step is already qualified by the cycle enable.
module aud_down_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             div_wr,
    input  logic [CNT_W-1:0] div_data,
    output logic             underflow,
    output logic             toggle_q
);
    logic [CNT_W-1:0] div_q;
    logic [CNT_W-1:0] cnt_q;

    assign underflow = step && (cnt_q == '0);

    // Divisor register: takes writes at once, used only at reload.
    always_ff @(posedge clk) begin
        if (!rst_n)      div_q <= '0;
        else if (div_wr) div_q <= div_data;
    end

    // Count: decrement on a step, reload on underflow.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (underflow) cnt_q <= div_q;
        else if (step)      cnt_q <= cnt_q - 1'b1;
    end

    // Toggle output: inverts on every underflow.
    always_ff @(posedge clk) begin
        if (!rst_n)         toggle_q <= 1'b0;
        else if (underflow) toggle_q <= ~toggle_q;
    end

    // R5: underflow reloads the divisor held before the edge
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> (cnt_q == $past(div_q)));

    // R6, R11: without a step the count is untouched, whatever is written
    a_r6_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt_q));

    // R5: the toggle changes only on underflow
    a_r5_toggle_only_uf: assert property (@(posedge clk) disable iff (!rst_n)
        !underflow |=> $stable(toggle_q));
endmodule

// File: rtl/aud_irq_ctrl.sv
// Interrupt enable and latched request for one channel.
// The request is set by an underflow while enabled and is cleared by writing the
// enable to 0. A clear in the same cycle as an underflow wins.
module aud_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic underflow,
    input  logic en_wr,
    input  logic en_data,
    output logic flag_q,
    output logic line_n
);
    logic en_q;
    logic clr;

    assign clr = en_wr && !en_data;

    // Enable register written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= 1'b0;
        else if (en_wr) en_q <= en_data;
    end

    // Request latch: clear has priority over set.
    always_ff @(posedge clk) begin
        if (!rst_n)                   flag_q <= 1'b0;
        else if (clr)                 flag_q <= 1'b0;
        else if (underflow && en_q)   flag_q <= 1'b1;
    end

    assign line_n = ~flag_q;

    // R10: a write of 0 to the enable leaves no request next cycle
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !flag_q);

    // R9: with the enable off and not being turned on, no request appears
    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !(en_wr && en_data)) |=> !flag_q);

    // R8: an enabled underflow without a clear raises the request
    a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && en_q && !clr) |=> flag_q);
endmodule

// File: rtl/aud_timer_chan.sv
// Top of the prescaled audio-channel interval timer.
// Selects the counter step source (delayed base tick or every enabled cycle)
// combinationally, so a base-select change applies from the next edge.
// Assumes: register writes are accepted regardless of cyc_en.
module aud_timer_chan
    import aud_timer_pkg::*;
#(
    parameter int unsigned PRE_DIV   = PRE_DIV_DEF,
    parameter int unsigned START_GAP = START_GAP_DEF,
    parameter int unsigned PIPE_DLY  = PIPE_DLY_DEF,
    parameter int unsigned CNT_W     = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             div_wr,
    input  logic [CNT_W-1:0] div_data,
    input  logic             fast_sel,
    input  logic             irq_en_wr,
    input  logic             irq_en_data,
    input  logic             init_hold,
    output logic             toggle_out,
    output logic             irq_flag,
    output logic             irq_n
);
    base_sel_e base_sel;
    logic      base_tick;
    logic      step;
    logic      underflow;

    assign base_sel = base_sel_e'(fast_sel);

    aud_prescaler #(
        .PRE_DIV  (PRE_DIV),
        .START_GAP(START_GAP),
        .PIPE_DLY (PIPE_DLY)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_en   (cyc_en),
        .init_hold(init_hold),
        .tick_out (base_tick)
    );

    // Step source select, qualified by the cycle enable.
    always_comb begin
        unique case (base_sel)
            BASE_CPU:       step = cyc_en;
            BASE_PRESCALED: step = cyc_en && base_tick;
            default:        step = 1'b0;
        endcase
    end

    aud_down_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .div_wr   (div_wr),
        .div_data (div_data),
        .underflow(underflow),
        .toggle_q (toggle_out)
    );

    aud_irq_ctrl u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .underflow(underflow),
        .en_wr    (irq_en_wr),
        .en_data  (irq_en_data),
        .flag_q   (irq_flag),
        .line_n   (irq_n)
    );

    // R11: a stalled cycle enable never changes the toggle
    a_r11_stall_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_en |=> $stable(toggle_out));

    // R8: the IRQ line mirrors the latched request
    a_r8_line: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n != irq_flag);
endmodule

// File: tb/aud_timer_chan_test.sv
// Self-checking bench for aud_timer_chan: cycle-counted intervals, divisor sweep.
module aud_timer_chan_test;
    localparam int PRE = 28;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b1;
    logic       div_wr = 1'b0;
    logic [7:0] div_data = '0;
    logic       fast_sel = 1'b0;
    logic       irq_en_wr = 1'b0;
    logic       irq_en_data = 1'b0;
    logic       init_hold = 1'b1;
    logic       toggle_out, irq_flag, irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    aud_timer_chan uut (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .div_wr(div_wr),
        .div_data(div_data), .fast_sel(fast_sel), .irq_en_wr(irq_en_wr),
        .irq_en_data(irq_en_data), .init_hold(init_hold),
        .toggle_out(toggle_out), .irq_flag(irq_flag), .irq_n(irq_n)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count posedges until toggle_out changes (sampled at negedges).
    task automatic next_edge(output int n);
        logic p;
        p = toggle_out;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (toggle_out == p && n < 10000);
    endtask

    task automatic wr_div(input int d);
        div_wr = 1'b1; div_data = 8'(d);
        @(negedge clk);
        div_wr = 1'b0;
    endtask

    task automatic wr_en(input bit v);
        irq_en_wr = 1'b1; irq_en_data = v;
        @(negedge clk);
        irq_en_wr = 1'b0;
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n, old, m;
        bit t0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 toggle", toggle_out, 0);
        check("R1 irq_flag", irq_flag, 0);
        check("R1 irq_n", irq_n, 1);

        // R3 init release latency: divisor 0, enable on; counter at 0 underflows at first step
        wr_div(0);
        wr_en(1'b1);
        repeat (5) @(negedge clk);
        check("R3 no step while held", toggle_out, 0);
        init_hold = 1'b0;
        next_edge(n);
        check("R3 first step after release", n, 9);
        check("R8 flag set on underflow", irq_flag, 1);
        check("R8 irq_n low", irq_n, 0);
        next_edge(n);
        check("R2 base tick spacing", n, PRE);

        // R10 clear, then R9 ignore while disabled
        wr_en(1'b0);
        check("R10 flag cleared", irq_flag, 0);
        check("R10 irq_n released", irq_n, 1);
        next_edge(n);
        check("R9 flag stays clear", irq_flag, 0);
        check("R9 irq_n high", irq_n, 1);
        wr_en(1'b1);
        next_edge(n);
        check("R8 flag set again", irq_flag, 1);
        wr_en(1'b0);

        // R6 deferred reload, R5 new period on base tick
        next_edge(n);
        wr_div(6);
        next_edge(n);
        check("R6 running interval keeps old divisor", n + 1, PRE);
        next_edge(n);
        check("R5 period divisor 6", n, 7 * PRE);

        // R7 immediate switch to CPU clock right after an underflow
        next_edge(n);
        fast_sel = 1'b1;
        next_edge(n);
        check("R7 switch applies next edge", n, 7);
        next_edge(n);
        check("R7 fast period", n, 7);

        // R4 init does not stop the CPU path
        init_hold = 1'b1;
        next_edge(n);
        check("R4 fast path under init", n, 7);
        next_edge(n);
        check("R4 fast path under init again", n, 7);
        init_hold = 1'b0;

        // R11 stall freezes counting
        next_edge(n);
        cyc_en = 1'b0;
        t0 = toggle_out;
        repeat (40) @(negedge clk);
        check("R11 toggle frozen while stalled", toggle_out, t0);
        cyc_en = 1'b1;
        next_edge(n);
        check("R11 interval counts enabled cycles", n, 7);

        // Back to base tick; resync, then sweep divisors
        fast_sel = 1'b0;
        next_edge(n);
        next_edge(n);
        old = 6;
        for (int d = 0; d <= 32; d++) begin
            m = (d == 32) ? 255 : d;
            wr_div(m);
            next_edge(n);
            check("R6 sweep old interval", n + 1, (old + 1) * PRE);
            next_edge(n);
            check("R5 sweep period", n, (m + 1) * PRE);
            old = m;
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule